// File: doc/BRIEF.md
# SPI Master Serial Clock Rate Generator

This block derives the serial clock of an SPI master from the bus clock. Two counters sit in series: a linear prescaler that divides the bus clock by an integer from 1 to 8, and a binary stage that divides the prescaler output by a power of two from 2 to 512. The complete bus-clock-to-SCK ratio is therefore (prescale + 1) * 2^(rate + 1).

The generator runs only while the block is a master and a transfer is in progress. In every other state both counters are held at zero, no bit-rate tick is issued, and SCK sits at the idle level chosen by the polarity input. A one-cycle tick marks each SCK edge for the shift logic. The tick is high in the bus cycle just before each SCK transition.

Top module: `spi_bit_rate_gen`

## Requirements
- R1: While reset is asserted and directly after it, with the enables low, `sck_o` equals `cpol_i` and `tick_o` is 0.
- R2: The prescaler divides the bus clock by `pre_sel_i + 1`, where `pre_sel_i` is an unsigned value from 0 to 7.
- R3: Each SCK half-period lasts (`pre_sel_i` + 1) * 2^`rate_sel_i` bus cycles. The divider stage therefore divides the prescaler output by 2^(`rate_sel_i` + 1).
- R4: One full SCK period lasts (`pre_sel_i` + 1) * 2^(`rate_sel_i` + 1) bus cycles for every `pre_sel_i` from 0 to 7 and every `rate_sel_i` from 0 to 8.
- R5: The counters run only when `master_i` and `xfer_i` are both 1. Otherwise `tick_o` is 0, `sck_o` equals `cpol_i` in the same cycle, and both counters clear at the next clock edge.
- R6: A `rate_sel_i` value from 9 to 15 is reserved and gives the same timing as value 8 (divide by 512).
- R7: When the generator becomes enabled, both counters start from zero. The first SCK transition follows the enabling clock edge by exactly one half-period, counted in rising edges. This also applies after a transfer is aborted and restarted.
- R8: `tick_o` is high for one bus cycle before each SCK transition, so exactly two ticks occur per SCK period. `sck_o` flips at the clock edge that ends a tick cycle.
- R9: The idle level is set by `cpol_i`. The first transition of a transfer goes from `cpol_i` to its inverse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| master_i | input | 1 | Block is configured as master |
| xfer_i | input | 1 | A serial transfer is in progress |
| pre_sel_i | input | 3 | Prescale select, divide by value + 1 |
| rate_sel_i | input | 4 | Rate select, divide by 2^(value + 1), 9 to 15 clamp to 8 |
| cpol_i | input | 1 | SCK idle level |
| tick_o | output | 1 | One-cycle pulse before each SCK edge |
| sck_o | output | 1 | Serial clock level |

## Verification
The bench measures the first-edge delay and the full SCK period for all 72 legal field combinations. A design with an off-by-one terminal count or a mis-wired exponent shows wrong counts for some combinations, and a small prescale with a large rate tells a swapped product from a correct one. Reserved rate codes are run at two prescale values, so a design that wraps the exponent or uses its low bits shows a short period. The bench aborts and restarts a transfer, and runs slave-only and master-idle states. A design that keeps stale counts across a restart shows a first edge that comes too early, and one that lets the counters run when gated produces ticks or an SCK that is not idle.

// File: rtl/spi_rate_pkg.sv
package spi_rate_pkg;
  parameter int unsigned PRE_W    = 3;  // prescale select width
  parameter int unsigned RATE_W   = 4;  // rate select width
  parameter int unsigned MAX_EXP  = 8;  // largest legal rate code (divide by 512)
  localparam int unsigned DIV_W   = (MAX_EXP > 0) ? MAX_EXP : 1;

  // reserved codes fold onto the slowest legal rate
  function automatic logic [RATE_W-1:0] clamp_rate(input logic [RATE_W-1:0] sel);
    if (sel > RATE_W'(MAX_EXP)) return RATE_W'(MAX_EXP);
    return sel;
  endfunction
endpackage

// File: rtl/spi_rate_prescaler.sv
module spi_rate_prescaler #(
  parameter int unsigned W = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic [W-1:0] sel_i,
  output logic         tc_o
);
  logic [W-1:0] cnt_q;

  assign tc_o = en_i && (cnt_q == sel_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (!en_i || tc_o)    cnt_q <= '0;
    else                       cnt_q <= cnt_q + W'(1);
  end

  // R2
  pre_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && $stable(sel_i)) |-> (cnt_q <= sel_i));
  // R5
  pre_gated_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (cnt_q == '0));
endmodule

// File: rtl/spi_rate_divider.sv
module spi_rate_divider #(
  parameter int unsigned DW = 8,
  parameter int unsigned EW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          step_i,
  input  logic [EW-1:0] exp_i,
  output logic          tc_o
);
  logic [DW-1:0] cnt_q;
  logic [DW:0]   one_sh;
  logic [DW-1:0] lim;

  // half-period in prescaler steps is 2^exp
  always_comb begin
    one_sh = (DW+1)'(1) << exp_i;
    lim    = DW'(one_sh - (DW+1)'(1));
  end

  assign tc_o = step_i && (cnt_q == lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (!en_i)     cnt_q <= '0;
    else if (tc_o)      cnt_q <= '0;
    else if (step_i)    cnt_q <= cnt_q + DW'(1);
  end

  // R3
  div_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && $stable(exp_i)) |-> (cnt_q <= lim));
  // R5
  div_gated_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (cnt_q == '0));
endmodule

// File: rtl/spi_rate_sck.sv
module spi_rate_sck (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic tick_i,
  input  logic cpol_i,
  output logic sck_o
);
  logic phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      phase_q <= 1'b0;
    else if (!en_i)   phase_q <= 1'b0;
    else if (tick_i)  phase_q <= ~phase_q;
  end

  // idle level returns in the same cycle the enable drops
  assign sck_o = cpol_i ^ (en_i & phase_q);

  // R8
  sck_toggle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && tick_i) |=> (!en_i || !$stable(cpol_i) || (sck_o != $past(sck_o))));
  // R8
  sck_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !tick_i) |=> (!en_i || !$stable(cpol_i) || $stable(sck_o)));
endmodule

// File: rtl/spi_bit_rate_gen.sv
module spi_bit_rate_gen
  import spi_rate_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              master_i,
  input  logic              xfer_i,
  input  logic [PRE_W-1:0]  pre_sel_i,
  input  logic [RATE_W-1:0] rate_sel_i,
  input  logic              cpol_i,
  output logic              tick_o,
  output logic              sck_o
);
  logic              run;
  logic              pre_tc;
  logic [RATE_W-1:0] rate_exp;

  assign run      = master_i & xfer_i;
  assign rate_exp = clamp_rate(rate_sel_i);

  spi_rate_prescaler #(.W(PRE_W)) u_pre (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (run),
    .sel_i (pre_sel_i),
    .tc_o  (pre_tc)
  );

  spi_rate_divider #(.DW(DIV_W), .EW(RATE_W)) u_div (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (run),
    .step_i(pre_tc),
    .exp_i (rate_exp),
    .tc_o  (tick_o)
  );

  spi_rate_sck u_sck (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (run),
    .tick_i(tick_o),
    .cpol_i(cpol_i),
    .sck_o (sck_o)
  );

  // R5
  no_tick_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run |-> !tick_o);
  // R7
  start_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(run) && $stable(cpol_i)) |-> (sck_o == cpol_i));
endmodule

// File: tb/spi_bit_rate_gen_tb_top.sv
`timescale 1ns/1ps
module spi_bit_rate_gen_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       master_i = 1'b0;
  logic       xfer_i = 1'b0;
  logic [2:0] pre_sel_i = '0;
  logic [3:0] rate_sel_i = '0;
  logic       cpol_i = 1'b0;
  logic       tick_o;
  logic       sck_o;

  int checks = 0;
  int errors = 0;

  always #2 clk_i = ~clk_i;

  spi_bit_rate_gen dut_i (
    .clk_i, .rst_ni, .master_i, .xfer_i, .pre_sel_i, .rate_sel_i,
    .cpol_i, .tick_o, .sck_o
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // counts rising edges until sck leaves 'from'; counts ticks seen on the way
  task automatic wait_change(input logic from, input int lim, output int n, output int t);
    n = 0; t = 0;
    forever begin
      #1;
      if (tick_o) t++;
      @(negedge clk_i);
      n++;
      if (sck_o != from || n >= lim) break;
    end
  endtask

  task automatic stop_xfer();
    @(negedge clk_i);
    xfer_i = 1'b0;
    master_i = 1'b0;
    repeat (2) @(negedge clk_i);
  endtask

  task automatic run_combo(input int p, input int r, input int h, input logic pol, input string tag);
    int n1, t1, n2, t2, n3, t3;
    @(negedge clk_i);
    pre_sel_i = 3'(p); rate_sel_i = 4'(r); cpol_i = pol;
    master_i = 1'b1; xfer_i = 1'b1;
    wait_change(pol, 4*h + 8, n1, t1);
    wait_change(~pol, 4*h + 8, n2, t2);
    wait_change(pol, 4*h + 8, n3, t3);
    chk(n1 == h, $sformatf("R7 first edge %s p=%0d r=%0d", tag, p, r), n1, h);
    chk(n2 + n3 == 2*h, $sformatf("R4 period %s p=%0d r=%0d", tag, p, r), n2 + n3, 2*h);
    chk(t1 == 1 && t2 == 1 && t3 == 1, $sformatf("R8 ticks %s p=%0d r=%0d", tag, p, r),
        t1 + t2 + t3, 3);
    stop_xfer();
  endtask

  task automatic t_reset();
    #1;
    chk(sck_o == 1'b0, "R1 sck in reset", sck_o, 0);
    chk(tick_o == 1'b0, "R1 tick in reset", tick_o, 0);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    chk(sck_o == 1'b0 && tick_o == 1'b0, "R1 after reset", {sck_o, tick_o}, 0);
  endtask

  task automatic t_sweep();
    for (int p = 0; p < 8; p++)
      for (int r = 0; r <= 8; r++)
        run_combo(p, r, (p + 1) * (1 << r), 1'b0, "R2 R3 sweep");
  endtask

  task automatic t_reserved();
    for (int r = 9; r < 16; r++) begin
      run_combo(0, r, 256, 1'b0, "R6 reserved");
      run_combo(2, r, 768, 1'b1, "R6 reserved");
    end
  endtask

  task automatic t_polarity();
    run_combo(0, 0, 1, 1'b1, "R9 cpol1");
    run_combo(3, 2, 16, 1'b1, "R9 cpol1");
    @(negedge clk_i); #1;
    chk(sck_o == 1'b1, "R9 idle high", sck_o, 1);
    cpol_i = 1'b0; #1;
    chk(sck_o == 1'b0, "R9 idle low", sck_o, 0);
  endtask

  task automatic t_gating();
    int t;
    int bad;
    @(negedge clk_i);
    pre_sel_i = 3'd0; rate_sel_i = 4'd0; cpol_i = 1'b0;
    master_i = 1'b0; xfer_i = 1'b1;
    t = 0; bad = 0;
    repeat (100) begin
      @(negedge clk_i); #1;
      if (tick_o) t++;
      if (sck_o != cpol_i) bad++;
    end
    chk(t == 0 && bad == 0, "R5 slave mode silent", t + bad, 0);
    master_i = 1'b1; xfer_i = 1'b0;
    t = 0; bad = 0;
    repeat (100) begin
      @(negedge clk_i); #1;
      if (tick_o) t++;
      if (sck_o != cpol_i) bad++;
    end
    chk(t == 0 && bad == 0, "R5 master no transfer silent", t + bad, 0);
    // abort mid half-period after first edge, then restart
    pre_sel_i = 3'd1; rate_sel_i = 4'd2; cpol_i = 1'b1;
    @(negedge clk_i);
    xfer_i = 1'b1;
    repeat (11) @(negedge clk_i);
    chk(sck_o == 1'b0, "R7 mid transfer level", sck_o, 0);
    xfer_i = 1'b0; #1;
    chk(sck_o == 1'b1 && tick_o == 1'b0, "R5 abort idles at once", {sck_o, tick_o}, 2);
    @(negedge clk_i);
    stop_xfer();
    run_combo(1, 2, 8, 1'b1, "R7 restart");
  endtask

  initial begin
    #(4 * 190000);
    errors++; checks++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_gating();
    t_polarity();
    t_sweep();
    t_reserved();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule